// File: doc/BRIEF.md
# Display RAM Host Access Port

This block is the front end through which a host processor reaches the frame memory of a display driver. The host drives an asynchronous parallel bus in the 8080 style. The bus carries an active-low chip select, a register-select line, separate active-low read and write strobes, and an 8-bit data bus. With register-select low, a write is a command that loads part of a column (X) or row (Y) pointer. With register-select high, a strobe moves one byte between the bus and the memory cell at the current pointer pair.

Each strobe is brought into the core clock domain through a synchronizer, and the block acts when the strobe returns high. Each pointer is 7 bits wide and takes two commands: the low nibble first, then the top three bits. Reads go through a one-stage prefetch buffer. For this reason the first read after a pointer change or after a data write is a dummy, and the bytes that follow stream out with the column pointer advancing. Rows 00h to 51h are backed by storage, and the last two of those rows hold icon data. Higher rows are reserved. A second, read-only port lets the panel-scan logic fetch any cell with one clock of latency.

Top module: `disp_ram_host_port`

## Requirements
- R1: After reset both pointers are zero and the next read is a dummy. That read drives 00h while it is on the bus.
- R2: When cs_n is high at a strobe, the strobe has no effect on the pointers, the memory or the read buffer.
- R3: A write with rs=0 is a command. Bits 7:4 select it: 0h loads X[3:0] from bits 3:0, 1h loads X[6:4] from bits 2:0, 2h loads Y[3:0] from bits 3:0, and 3h loads Y[6:4] from bits 2:0. Bit 3 of a high command is ignored, and any other opcode changes nothing.
- R4: A write with rs=1 stores the data byte at the current (X,Y) and then adds one to X.
- R5: The first rs=1 read after any pointer command, after a data write, or after reset is a dummy. It returns the old buffer contents and leaves X unchanged.
- R6: Each later rs=1 read returns the byte at the X value it started with, and then adds one to X.
- R7: X wraps from 7Fh to 00h. Data accesses never change Y.
- R8: Rows 52h to 7Fh are reserved: data writes there are discarded and reads there return 00h. Rows 50h and 51h (icon rows) behave like any other backed row.
- R9: Columns at or above the parameter COLS (default 32) are unbacked and behave like reserved rows. X still advances across them.
- R10: dout_oe is high exactly while cs_n and rd_n are both low. While it stays high, dout does not change.
- R11: The scan port returns the stored byte at (scan_x, scan_y) one clock later, and returns 00h for an unbacked or reserved cell.
- R12: A write takes effect in the memory within four clock edges of the rising write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | 0 = command, 1 = display data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Data bus, host to block |
| dout | output | 8 | Data bus, block to host |
| dout_oe | output | 1 | Bus driver enable for dout |
| scan_x | input | 7 | Scan port column |
| scan_y | input | 7 | Scan port row |
| scan_q | output | 8 | Scan port read data |

## Verification
The assertions assume the host meets the bus timing of a slow asynchronous interface. cs_n, rs and din stay steady from before a strobe falls until several clocks after it rises. Read and write strobes are never low at the same time. Consecutive strobes are separated by enough clocks for the synchronizer and the prefetch to finish. The stimulus tasks enforce these conditions: each one sets up the control and data lines two clocks early, holds the strobe low for four clocks, and waits six clocks after the strobe rises before anything else changes. Under these conditions the output-stability and pointer-step properties can be stated per strobe event.

// File: rtl/disp_host_pkg.sv
`timescale 1ns/1ps
package disp_host_pkg;

    localparam int AW = 7;
    localparam int DW = 8;

    typedef enum logic [3:0] {
        OP_XLO = 4'h0,
        OP_XHI = 4'h1,
        OP_YLO = 4'h2,
        OP_YHI = 4'h3
    } op_e;

    typedef struct packed {
        logic set_xlo;
        logic set_xhi;
        logic set_ylo;
        logic set_yhi;
        logic data_wr;
        logic data_rd;
    } bus_act_t;

    typedef struct packed {
        logic [AW-1:0] x;
        logic [AW-1:0] y;
        logic          dummy;
        logic          fetch;
        logic [DW-1:0] rdbuf;
    } core_st_t;

    function automatic logic cell_backed(logic [AW-1:0] x, logic [AW-1:0] y,
                                         int cols, int rows);
        return (int'(x) < cols) && (int'(y) < rows);
    endfunction

endpackage

// File: rtl/disp_strobe_edge.sv
`timescale 1ns/1ps
module disp_strobe_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);
    localparam int LEN = SYNC_STAGES + 1;

    logic [LEN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[LEN-2:0], strobe_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    // strobe released: synchronized level high, previous stage still low
    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/disp_cmd_decode.sv
`timescale 1ns/1ps
module disp_cmd_decode
    import disp_host_pkg::*;
(
    input  logic     cs_n,
    input  logic     rs,
    input  logic     wr_rise,
    input  logic     rd_rise,
    input  logic [3:0] opcode,
    output bus_act_t act
);
    always_comb begin
        act = '0;
        if (!cs_n) begin
            if (wr_rise) begin
                if (rs) begin
                    act.data_wr = 1'b1;
                end else begin
                    case (op_e'(opcode))
                        OP_XLO:  act.set_xlo = 1'b1;
                        OP_XHI:  act.set_xhi = 1'b1;
                        OP_YLO:  act.set_ylo = 1'b1;
                        OP_YHI:  act.set_yhi = 1'b1;
                        default: act = '0;
                    endcase
                end
            end else if (rd_rise && rs) begin
                act.data_rd = 1'b1;
            end
        end
    end

endmodule

// File: rtl/disp_dpram.sv
`timescale 1ns/1ps
module disp_dpram #(
    parameter int COLS = 32,
    parameter int ROWS = 82,
    parameter int AW   = 7,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic [AW-1:0] a_x,
    input  logic [AW-1:0] a_y,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_q,
    input  logic [AW-1:0] b_x,
    input  logic [AW-1:0] b_y,
    output logic [DW-1:0] b_q
);
    localparam int DEPTH = COLS * ROWS;
    localparam int IDX_W = $clog2(DEPTH);

    logic [DW-1:0]    mem [DEPTH];
    logic             a_ok, b_ok;
    logic [IDX_W-1:0] a_idx, b_idx;

    always_comb begin
        a_ok  = (int'(a_x) < COLS) && (int'(a_y) < ROWS);
        b_ok  = (int'(b_x) < COLS) && (int'(b_y) < ROWS);
        a_idx = a_ok ? IDX_W'(int'(a_y) * COLS + int'(a_x)) : '0;
        b_idx = b_ok ? IDX_W'(int'(b_y) * COLS + int'(b_x)) : '0;
    end

    always_ff @(posedge clk) begin
        if (a_we && a_ok) mem[a_idx] <= a_wdata;
        a_q <= a_ok ? mem[a_idx] : '0;
        b_q <= b_ok ? mem[b_idx] : '0;
    end

endmodule

// File: rtl/disp_ram_host_port.sv
`timescale 1ns/1ps
module disp_ram_host_port
    import disp_host_pkg::*;
#(
    parameter int COLS        = 32,
    parameter int ROWS        = 82,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rs,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    input  logic [AW-1:0] scan_x,
    input  logic [AW-1:0] scan_y,
    output logic [DW-1:0] scan_q
);
    localparam core_st_t ST_RST = '{x: '0, y: '0, dummy: 1'b1, fetch: 1'b0, rdbuf: '0};

    logic          wr_rise, rd_rise;
    bus_act_t      act;
    core_st_t      st_d, st_q;
    logic          ram_we;
    logic [AW-1:0] ram_x, fetch_x;
    logic          fetch_req;
    logic [DW-1:0] ram_q;

    // signals brought out for the bound checker
    logic [AW-1:0] cur_x, cur_y;
    logic          cur_dummy;

    disp_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) i_wr_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n(wr_n), .rise(wr_rise)
    );

    disp_strobe_edge #(.SYNC_STAGES(SYNC_STAGES)) i_rd_edge (
        .clk(clk), .rst_n(rst_n), .strobe_n(rd_n), .rise(rd_rise)
    );

    disp_cmd_decode i_decode (
        .cs_n(cs_n), .rs(rs), .wr_rise(wr_rise), .rd_rise(rd_rise),
        .opcode(din[7:4]), .act(act)
    );

    always_comb begin
        st_d      = st_q;
        ram_we    = 1'b0;
        fetch_req = 1'b0;
        fetch_x   = st_q.x;

        if (act.set_xlo) begin
            st_d.x[3:0] = din[3:0];
            st_d.dummy  = 1'b1;
        end
        if (act.set_xhi) begin
            st_d.x[6:4] = din[2:0];
            st_d.dummy  = 1'b1;
        end
        if (act.set_ylo) begin
            st_d.y[3:0] = din[3:0];
            st_d.dummy  = 1'b1;
        end
        if (act.set_yhi) begin
            st_d.y[6:4] = din[2:0];
            st_d.dummy  = 1'b1;
        end

        if (act.data_wr) begin
            ram_we     = cell_backed(st_q.x, st_q.y, COLS, ROWS);
            st_d.x     = st_q.x + AW'(1);
            st_d.dummy = 1'b1;
        end

        if (act.data_rd) begin
            fetch_req = 1'b1;
            if (st_q.dummy) begin
                st_d.dummy = 1'b0;
            end else begin
                st_d.x  = st_q.x + AW'(1);
                fetch_x = st_q.x + AW'(1);
            end
        end

        st_d.fetch = fetch_req;
        if (st_q.fetch) st_d.rdbuf = ram_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        ram_x = ram_we ? st_q.x : fetch_x;
    end

    disp_dpram #(.COLS(COLS), .ROWS(ROWS), .AW(AW), .DW(DW)) i_ram (
        .clk(clk), .a_we(ram_we), .a_x(ram_x), .a_y(st_q.y), .a_wdata(din),
        .a_q(ram_q), .b_x(scan_x), .b_y(scan_y), .b_q(scan_q)
    );

    assign dout      = st_q.rdbuf;
    assign dout_oe   = ~cs_n & ~rd_n;
    assign cur_x     = st_q.x;
    assign cur_y     = st_q.y;
    assign cur_dummy = st_q.dummy;

endmodule

// File: rtl/disp_ram_host_chk.sv
`timescale 1ns/1ps
module disp_ram_host_chk #(
    parameter int COLS = 32,
    parameter int ROWS = 82
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       wr_rise,
    input logic       rd_rise,
    input logic       data_wr,
    input logic       data_rd,
    input logic       ram_we,
    input logic       dummy,
    input logic [6:0] x,
    input logic [6:0] y,
    input logic [7:0] dout,
    input logic       dout_oe
);
    // R2: a deselected strobe leaves both pointers alone
    a_r2_cs_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rise || rd_rise) && cs_n |=> $stable(x) && $stable(y));

    // R4 / R7: every data write steps X by one, with wrap
    a_r4_write_steps_x: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> x == $past(x) + 7'd1);

    // R5: a dummy read keeps X
    a_r5_dummy_holds_x: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && dummy |=> $stable(x) && !dummy);

    // R6: a real read steps X
    a_r6_read_steps_x: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && !dummy |=> x == $past(x) + 7'd1);

    // R7: data traffic never moves Y
    a_r7_y_kept: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr || data_rd |=> $stable(y));

    // R8 / R9: no store lands outside the backed area
    a_r8_no_reserved_store: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (int'(y) < ROWS) && (int'(x) < COLS));

    // R10: bus data held steady during a read pulse
    a_r10_bus_steady: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe && $past(dout_oe) |-> $stable(dout));

endmodule

bind disp_ram_host_port disp_ram_host_chk #(.COLS(COLS), .ROWS(ROWS)) i_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rise(wr_rise), .rd_rise(rd_rise),
    .data_wr(act.data_wr), .data_rd(act.data_rd), .ram_we(ram_we),
    .dummy(cur_dummy), .x(cur_x), .y(cur_y), .dout(dout), .dout_oe(dout_oe)
);

// File: tb/test_disp_ram_host_port.sv
`timescale 1ns/1ps
module test_disp_ram_host_port;

    localparam int COLS = 32;
    localparam int ROWS = 82;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rs = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] din = '0;
    logic [7:0] dout, scan_q;
    logic       dout_oe;
    logic [6:0] scan_x = '0, scan_y = '0;

    int    compared = 0;
    int    mismatched = 0;
    bit    run = 1'b0;
    string cur_req = "R1";

    // behavioural reference
    logic [6:0] mx = '0, my = '0;
    bit         mdummy = 1'b1;
    logic [7:0] mbuf = '0;
    bit         mbuf_known = 1'b1;
    logic [7:0] mmem [int];

    always #2.5 clk = ~clk;

    disp_ram_host_port #(.COLS(COLS), .ROWS(ROWS)) i_disp_ram_host_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rd_n(rd_n), .wr_n(wr_n),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .scan_x(scan_x), .scan_y(scan_y), .scan_q(scan_q)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit backed(logic [6:0] x, logic [6:0] y);
        return (int'(x) < COLS) && (int'(y) < ROWS);
    endfunction

    function automatic int key(logic [6:0] x, logic [6:0] y);
        return int'(y) * 128 + int'(x);
    endfunction

    task automatic model_fetch(logic [6:0] x);
        if (!backed(x, my)) begin
            mbuf = '0; mbuf_known = 1'b1;
        end else if (mmem.exists(key(x, my))) begin
            mbuf = mmem[key(x, my)]; mbuf_known = 1'b1;
        end else begin
            mbuf_known = 1'b0;
        end
    endtask

    task automatic model_wr(bit csn, bit r, logic [7:0] d);
        if (csn) return;
        if (!r) begin
            case (d[7:4])
                4'h0: begin mx[3:0] = d[3:0]; mdummy = 1'b1; end
                4'h1: begin mx[6:4] = d[2:0]; mdummy = 1'b1; end
                4'h2: begin my[3:0] = d[3:0]; mdummy = 1'b1; end
                4'h3: begin my[6:4] = d[2:0]; mdummy = 1'b1; end
                default: ;
            endcase
        end else begin
            if (backed(mx, my)) mmem[key(mx, my)] = d;
            mx = mx + 7'd1;
            mdummy = 1'b1;
        end
    endtask

    task automatic model_rd(bit csn, bit r);
        if (csn || !r) return;
        if (mdummy) begin
            mdummy = 1'b0;
        end else begin
            mx = mx + 7'd1;
        end
        model_fetch(mx);
    endtask

    // R12: the strobe is released, then six clocks pass before lines change
    task automatic bus_wr(bit csn, bit r, logic [7:0] d);
        @(posedge clk); #1;
        cs_n = csn; rs = r; din = d;
        repeat (2) @(posedge clk); #1 wr_n = 1'b0;
        repeat (4) @(posedge clk); #1 wr_n = 1'b1;
        model_wr(csn, r, d);
        repeat (6) @(posedge clk); #1 cs_n = 1'b1;
    endtask

    task automatic bus_rd(bit csn, bit r);
        @(posedge clk); #1;
        cs_n = csn; rs = r;
        repeat (2) @(posedge clk); #1 rd_n = 1'b0;
        repeat (4) @(posedge clk); #1 rd_n = 1'b1;
        model_rd(csn, r);
        repeat (6) @(posedge clk); #1 cs_n = 1'b1;
    endtask

    task automatic set_x(logic [6:0] v);
        bus_wr(1'b0, 1'b0, {4'h0, v[3:0]});
        bus_wr(1'b0, 1'b0, {4'h1, 1'b0, v[6:4]});
    endtask

    task automatic set_y(logic [6:0] v);
        bus_wr(1'b0, 1'b0, {4'h2, v[3:0]});
        bus_wr(1'b0, 1'b0, {4'h3, 1'b0, v[6:4]});
    endtask

    task automatic scan_chk(string req, logic [6:0] x, logic [6:0] y);
        scan_x = x; scan_y = y;
        repeat (2) @(posedge clk); #1;
        if (!backed(x, y)) check(req, scan_q, 8'h00);
        else if (mmem.exists(key(x, y))) check(req, scan_q, mmem[key(x, y)]);
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (run) begin
            check("R10", {7'd0, dout_oe}, {7'd0, (!cs_n && !rd_n)});
            if (!cs_n && !rd_n && mbuf_known) check(cur_req, dout, mbuf);
        end
    end

    initial begin
        #(5.0 * 100000);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        run = 1'b1;
        @(posedge clk); #1;
        check("R1", {7'd0, dout_oe}, 8'h00);

        // R1: dummy after reset shows 00h
        cur_req = "R1";
        bus_rd(1'b0, 1'b1);

        // R3, R4, R12: load (5,3), write three bytes
        cur_req = "R4";
        set_x(7'h05); set_y(7'h03);
        scan_x = 7'h05; scan_y = 7'h03;
        bus_wr(1'b0, 1'b1, 8'hAA);
        check("R12", scan_q, 8'hAA);
        bus_wr(1'b0, 1'b1, 8'hBB);
        bus_wr(1'b0, 1'b1, 8'hCC);
        scan_chk("R4", 7'h06, 7'h03);

        // R5, R6: dummy then streaming reads
        cur_req = "R5";
        bus_wr(1'b0, 1'b0, 8'h05);
        bus_rd(1'b0, 1'b1);
        cur_req = "R6";
        for (int i = 0; i < 3; i++) bus_rd(1'b0, 1'b1);

        // R2: deselected transfers, then a real write must land at X=8
        cur_req = "R2";
        bus_wr(1'b1, 1'b1, 8'h11);
        bus_wr(1'b1, 1'b0, 8'h0F);
        bus_rd(1'b1, 1'b1);
        bus_wr(1'b0, 1'b1, 8'h77);
        scan_chk("R2", 7'h08, 7'h03);
        scan_chk("R2", 7'h09, 7'h03);

        // R3: bit 3 of the high commands ignored, unknown opcode ignored
        bus_wr(1'b0, 1'b0, 8'h01);
        bus_wr(1'b0, 1'b0, 8'h18);
        bus_wr(1'b0, 1'b0, 8'h24);
        bus_wr(1'b0, 1'b0, 8'h38);
        bus_wr(1'b0, 1'b0, 8'h47);
        bus_wr(1'b0, 1'b1, 8'h3C);
        scan_chk("R3", 7'h01, 7'h04);

        // R8: icon row works, reserved row dropped and reads zero
        cur_req = "R8";
        set_y(7'h51); set_x(7'h00);
        bus_wr(1'b0, 1'b1, 8'h5E);
        scan_chk("R8", 7'h00, 7'h51);
        bus_wr(1'b0, 1'b0, 8'h22);
        bus_wr(1'b0, 1'b1, 8'h99);
        bus_wr(1'b0, 1'b0, 8'h00);
        bus_rd(1'b0, 1'b1);
        bus_rd(1'b0, 1'b1);
        check("R8", dout, 8'h00);
        bus_wr(1'b0, 1'b0, 8'h21);
        bus_wr(1'b0, 1'b0, 8'h00);
        bus_rd(1'b0, 1'b1);
        bus_rd(1'b0, 1'b1);

        // R7, R9: unbacked column 7Fh, wrap to 00h, Y kept
        cur_req = "R9";
        set_y(7'h02); set_x(7'h7F);
        bus_wr(1'b0, 1'b1, 8'hD1);
        bus_wr(1'b0, 1'b1, 8'hD2);
        scan_chk("R7", 7'h00, 7'h02);
        set_x(7'h7F);
        bus_rd(1'b0, 1'b1);
        bus_rd(1'b0, 1'b1);
        cur_req = "R7";
        bus_rd(1'b0, 1'b1);
        bus_wr(1'b0, 1'b1, 8'hE4);
        scan_chk("R7", 7'h01, 7'h02);

        // R11: scan port outside the backed area
        scan_chk("R11", 7'h28, 7'h02);
        scan_chk("R11", 7'h00, 7'h60);
        scan_chk("R11", 7'h07, 7'h03);

        run = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule